// File: doc/BRIEF.md
# Programmable Sum-of-Products Plane

This block is the logic plane of a small programmable logic device. Twenty logic signals enter it, and each one is offered to the plane in true and in inverted form, which gives 40 literal columns. Sixty-four product-term rows each take the AND of the literals that a static fuse vector connects to that row. The rows form eight groups of eight, and each group feeds one output cell.

Each row has its own kill fuse that forces the term low. For every group the block returns two things. One is the leading term of the group on its own, so that a later output cell can use it as a drive-enable. The other is the OR of the group's terms. A per-group select removes the leading term from that OR, so that when it serves as an enable only the remaining seven terms build the data value. The configuration is a static input vector, and the block holds no state.

Top module: `sop_array`

## Requirements
- R1: Literal column 2*i carries `sigIn[i]` and column 2*i+1 carries its inverse. The fuse for row r, column c sits at bit 40*r + c of `fuseMap`, so the full array uses bits 0 to 2559.
- R2: A fuse bit of 1 leaves its column out of the row, and 0 puts it in. A row with every fuse at 1 that is not killed yields a term of 1.
- R3: A row that has a signal and its inverse both connected always yields 0. This includes the case where all fuses are 0.
- R4: `termVec[r]` equals the AND of the literals connected to row r, as long as `termOff[r]` is 0.
- R5: When `termOff[r]` is 1, `termVec[r]` reads 0 and row r adds nothing to its group's `sumOut`.
- R6: With `oeSel[g]` at 0, `sumOut[g]` is the OR of terms 8g through 8g+7.
- R7: With `oeSel[g]` at 1, `sumOut[g]` is the OR of terms 8g+1 through 8g+7 only, so a lone high leading term leaves `sumOut[g]` at 0.
- R8: `oeTerm[g]` equals the leading term 8g after its kill fuse is applied, whatever the value of `oeSel[g]`.
- R9: The block has no clock and no storage. Every output settles from its present inputs, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sigIn | input | 20 | Logic signals presented to the plane |
| fuseMap | input | 2560 | Connection fuses, row-major, 40 per row, 1 = open |
| termOff | input | 64 | Per-row kill fuse, 1 forces the term to 0 |
| oeSel | input | 8 | Per-group select: 1 reserves the leading term as enable |
| termVec | output | 64 | All product terms after the kill fuses |
| sumOut | output | 8 | Per-group OR of the terms that are allowed to contribute |
| oeTerm | output | 8 | Leading term of each group, after its kill fuse |

## Verification
Because the block has no state, a wrong literal order, fuse offset or inverted fuse sense shows up on `termVec` as soon as the inputs change. The single-literal sweep makes each of the 40 columns of a chosen row the only connection in turn, so an error in any one column position is caught. A mask that mishandles the enable select or a kill fuse shows up on `sumOut` or `oeTerm` in that same step. The directed group patterns make such an error decide the output on its own, rather than being hidden by another high term in the group.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

  parameter int SIG_COUNT       = 20;
  parameter int COL_COUNT       = 2 * SIG_COUNT;
  parameter int GROUP_COUNT     = 8;
  parameter int TERMS_PER_GROUP = 8;
  parameter int TERM_COUNT      = GROUP_COUNT * TERMS_PER_GROUP;
  parameter int FUSE_COUNT      = TERM_COUNT * COL_COUNT;

  // Strobes from control to datapath: which terms stay alive at all,
  // and which of them may feed their group's OR.
  typedef struct packed {
    logic [TERM_COUNT-1:0] live;
    logic [TERM_COUNT-1:0] orPass;
  } termStrobes_t;

endpackage

// File: rtl/sop_term_row.sv
module sop_term_row #(
  parameter int COLS = 40
) (
  input  logic [COLS-1:0] literals,
  input  logic [COLS-1:0] rowFuses,
  output logic            termRaw
);

  // An open fuse (1) forces its column to 1, so that column drops out of the AND.
  logic [COLS-1:0] masked;

  always_comb begin
    masked  = literals | rowFuses;
    termRaw = &masked;
  end

endmodule

// File: rtl/sop_array_ctrl.sv
module sop_array_ctrl
  import sop_array_pkg::*;
(
  input  logic [TERM_COUNT-1:0]  termOff,
  input  logic [GROUP_COUNT-1:0] oeSel,
  output termStrobes_t           strobes
);

  logic [TERM_COUNT-1:0] liveMask;
  logic [TERM_COUNT-1:0] passMask;

  for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_group
    for (genvar k = 0; k < TERMS_PER_GROUP; k++) begin : g_term
      localparam int ROW = g * TERMS_PER_GROUP + k;
      assign liveMask[ROW] = ~termOff[ROW];
      if (k == 0) begin : g_lead
        // The leading term leaves the OR when it is reserved as an enable.
        assign passMask[ROW] = ~termOff[ROW] & ~oeSel[g];
      end else begin : g_rest
        assign passMask[ROW] = ~termOff[ROW];
      end
    end
  end

  always_comb begin
    strobes.live   = liveMask;
    strobes.orPass = passMask;
  end

endmodule

// File: rtl/sop_array_dpath.sv
module sop_array_dpath
  import sop_array_pkg::*;
(
  input  logic [SIG_COUNT-1:0]   sigIn,
  input  logic [FUSE_COUNT-1:0]  fuseMap,
  input  termStrobes_t           strobes,
  output logic [TERM_COUNT-1:0]  termVec,
  output logic [GROUP_COUNT-1:0] sumOut,
  output logic [GROUP_COUNT-1:0] oeTerm
);

  logic [COL_COUNT-1:0]  literals;
  logic [TERM_COUNT-1:0] rawTerms;
  logic [TERM_COUNT-1:0] sumTerms;

  // Column 2i is the signal itself, column 2i+1 is its inverse.
  for (genvar i = 0; i < SIG_COUNT; i++) begin : g_lit
    assign literals[2*i]   = sigIn[i];
    assign literals[2*i+1] = ~sigIn[i];
  end

  for (genvar r = 0; r < TERM_COUNT; r++) begin : g_row
    sop_term_row #(.COLS(COL_COUNT)) u_row (
      .literals (literals),
      .rowFuses (fuseMap[r*COL_COUNT +: COL_COUNT]),
      .termRaw  (rawTerms[r])
    );
  end

  always_comb begin
    termVec  = rawTerms & strobes.live;
    sumTerms = rawTerms & strobes.orPass;
  end

  for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_sum
    localparam int BASE = g * TERMS_PER_GROUP;
    assign sumOut[g] = |sumTerms[BASE +: TERMS_PER_GROUP];
    assign oeTerm[g] = rawTerms[BASE] & strobes.live[BASE];
  end

endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_array_pkg::*;
(
  input  logic [SIG_COUNT-1:0]   sigIn,
  input  logic [FUSE_COUNT-1:0]  fuseMap,
  input  logic [TERM_COUNT-1:0]  termOff,
  input  logic [GROUP_COUNT-1:0] oeSel,
  output logic [TERM_COUNT-1:0]  termVec,
  output logic [GROUP_COUNT-1:0] sumOut,
  output logic [GROUP_COUNT-1:0] oeTerm
);

  termStrobes_t strobes;

  sop_array_ctrl u_ctrl (
    .termOff (termOff),
    .oeSel   (oeSel),
    .strobes (strobes)
  );

  sop_array_dpath u_dpath (
    .sigIn   (sigIn),
    .fuseMap (fuseMap),
    .strobes (strobes),
    .termVec (termVec),
    .sumOut  (sumOut),
    .oeTerm  (oeTerm)
  );

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk
  import sop_array_pkg::*;
(
  input logic [FUSE_COUNT-1:0]  fuseMap,
  input logic [TERM_COUNT-1:0]  termOff,
  input logic [GROUP_COUNT-1:0] oeSel,
  input logic [TERM_COUNT-1:0]  termVec,
  input logic [GROUP_COUNT-1:0] sumOut,
  input logic [GROUP_COUNT-1:0] oeTerm
);

  always_comb begin
    for (int r = 0; r < TERM_COUNT; r++) begin
      // R5
      killed_term_low_chk: assert (!(termOff[r] && termVec[r]))
        else $error("killed row %0d still high", r);
      // R2
      open_row_high_chk: assert (!(fuseMap[r*COL_COUNT +: COL_COUNT] == '1 && !termOff[r]) || termVec[r])
        else $error("open row %0d not high", r);
      // R3
      shorted_row_low_chk: assert (!(fuseMap[r*COL_COUNT +: COL_COUNT] == '0) || !termVec[r])
        else $error("fully connected row %0d not low", r);
    end
    for (int g = 0; g < GROUP_COUNT; g++) begin
      // R8
      lead_term_match_chk: assert (oeTerm[g] == termVec[g*TERMS_PER_GROUP])
        else $error("enable term of group %0d mismatch", g);
      // R7
      lead_excluded_chk: assert (!(oeSel[g] && termVec[g*TERMS_PER_GROUP+1 +: TERMS_PER_GROUP-1] == '0) || !sumOut[g])
        else $error("reserved lead term reached sum of group %0d", g);
      // R6
      sum_covers_terms_chk: assert (!(termVec[g*TERMS_PER_GROUP+1 +: TERMS_PER_GROUP-1] != '0) || sumOut[g])
        else $error("sum of group %0d misses a live term", g);
    end
  end

endmodule

bind sop_array sop_array_chk u_chk (
  .fuseMap (fuseMap),
  .termOff (termOff),
  .oeSel   (oeSel),
  .termVec (termVec),
  .sumOut  (sumOut),
  .oeTerm  (oeTerm)
);

// File: tb/sim_sop_array.sv
`timescale 1ns/1ps
module sim_sop_array;
  import sop_array_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [SIG_COUNT-1:0]   sigIn;
  logic [FUSE_COUNT-1:0]  fuseMap;
  logic [TERM_COUNT-1:0]  termOff;
  logic [GROUP_COUNT-1:0] oeSel;
  logic [TERM_COUNT-1:0]  termVec;
  logic [GROUP_COUNT-1:0] sumOut;
  logic [GROUP_COUNT-1:0] oeTerm;

  logic [TERM_COUNT-1:0]  expTerm;
  logic [GROUP_COUNT-1:0] expSum;
  logic [GROUP_COUNT-1:0] expOe;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  sop_array u0 (
    .sigIn (sigIn), .fuseMap (fuseMap), .termOff (termOff), .oeSel (oeSel),
    .termVec (termVec), .sumOut (sumOut), .oeTerm (oeTerm)
  );

  // Reference: literal 2i = signal i, 2i+1 = inverse; fuse at 40*r+c, 1 = open.
  task automatic model();
    for (int r = 0; r < TERM_COUNT; r++) begin
      logic t = 1'b1;
      for (int c = 0; c < COL_COUNT; c++) begin
        if (fuseMap[r*COL_COUNT + c] == 1'b0)
          t = t & ((c % 2 == 1) ? ~sigIn[c/2] : sigIn[c/2]);
      end
      expTerm[r] = t & ~termOff[r];
    end
    for (int g = 0; g < GROUP_COUNT; g++) begin
      logic s = 1'b0;
      expOe[g] = expTerm[g*TERMS_PER_GROUP];
      for (int k = 0; k < TERMS_PER_GROUP; k++)
        if (!(k == 0 && oeSel[g])) s = s | expTerm[g*TERMS_PER_GROUP + k];
      expSum[g] = s;
    end
  endtask

  task automatic checkAll(string req);
    model();
    testsRun += 3;
    if (termVec !== expTerm) begin
      testsFailed++;
      $display("FAIL %s termVec actual=%h expected=%h", req, termVec, expTerm);
    end
    if (sumOut !== expSum) begin
      testsFailed++;
      $display("FAIL %s sumOut actual=%b expected=%b", req, sumOut, expSum);
    end
    if (oeTerm !== expOe) begin
      testsFailed++;
      $display("FAIL %s oeTerm actual=%b expected=%b", req, oeTerm, expOe);
    end
  endtask

  // Drive away from the rising edge, sample 1 ns later with no edge between (R9).
  task automatic step(string req);
    #1;
    checkAll(req);
    @(negedge clk);
  endtask

  task automatic fixedCheck(string req, logic [TERM_COUNT-1:0] t,
                            logic [GROUP_COUNT-1:0] s, logic [GROUP_COUNT-1:0] o);
    #1;
    testsRun++;
    if (termVec !== t || sumOut !== s || oeTerm !== o) begin
      testsFailed++;
      $display("FAIL %s actual=%h/%b/%b expected=%h/%b/%b", req,
               termVec, sumOut, oeTerm, t, s, o);
    end
    @(negedge clk);
  endtask

  initial begin
    sigIn = '0; fuseMap = '1; termOff = '0; oeSel = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: all fuses open gives every term high
    fixedCheck("R2 open plane", '1, '1, '1);
    sigIn = 20'hABCDE;
    fixedCheck("R9 open plane after input change", '1, '1, '1);

    // R3: a fully connected plane is always low
    fuseMap = '0;
    for (int n = 0; n < 8; n++) begin
      sigIn = $urandom();
      fixedCheck("R3 shorted plane", '0, '0, '0);
    end

    // R1: single-literal sweep over every column of several rows
    foreach (sweepRows[i]) begin
      for (int c = 0; c < COL_COUNT; c++) begin
        fuseMap = '0;
        fuseMap[sweepRows[i]*COL_COUNT +: COL_COUNT] = '1;
        fuseMap[sweepRows[i]*COL_COUNT + c] = 1'b0;
        sigIn = '0;                  step("R1 column sweep zeros");
        sigIn = 20'(1) << (c/2);     step("R1 column sweep one-hot");
        sigIn = ~(20'(1) << (c/2));  step("R1 column sweep one-cold");
      end
    end

    // R5: kill each row of an open plane in turn
    fuseMap = '1; oeSel = '0;
    for (int r = 0; r < TERM_COUNT; r++) begin
      termOff = '0; termOff[r] = 1'b1;
      step("R5 single kill");
    end

    // R7/R8: only the leading term of each group high
    termOff = '0; fuseMap = '0;
    for (int g = 0; g < GROUP_COUNT; g++)
      fuseMap[g*TERMS_PER_GROUP*COL_COUNT +: COL_COUNT] = '1;
    oeSel = '0;  fixedCheck("R6 lead term in sum", 64'h0101010101010101, '1, '1);
    oeSel = '1;  fixedCheck("R7 lead term reserved", 64'h0101010101010101, '0, '1);
    termOff = 64'h0101010101010101;
    fixedCheck("R8 killed enable term", '0, '0, '0);
    termOff = '0; oeSel = 8'h5A;
    step("R7 mixed select");

    // R5/R7: open plane, every non-leading term of a group killed
    fuseMap = '1; oeSel = '1; termOff = 64'hFE00_0000_0000_FEFE;
    step("R5 group killed except lead");

    // R4/R6/R7/R8: random sparse planes
    for (int n = 0; n < 1500; n++) begin
      for (int b = 0; b < FUSE_COUNT; b++) fuseMap[b] = ($urandom() % 10) != 0;
      sigIn = $urandom();
      termOff = {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
      oeSel = $urandom();
      step("R4 random plane");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  int sweepRows [3] = '{0, 9, 63};

  initial begin
    #900000;
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule